// File: doc/BRIEF.md
# Unbuffered Serial Shift Unit

This block is an 8-bit shift register that a host bus reads and writes directly. There is no holding buffer, so a parallel read returns the live register and a parallel write replaces it. Each shift moves the contents one place toward bit 7 and fills bit 0 from the serial data input. The shift event comes from one of four selectable sources: a software strobe, a timer overflow pulse, a rising edge of an external serial clock, or a falling edge of that clock. The external clock passes through a synchronizer before its edges are detected.

The serial output follows bit 7 through an output latch. With an internal source (strobe or timer) the latch is always open, so a new MSB reaches the pin in the same cycle. With an external source the latch is open only during the half of the serial clock period that comes before the shifting edge. It holds during the other half, so the input is sampled on one serial clock edge and the output moves on the other.

Top module: `ser_shift_unit`

## Requirements
- R1: After a synchronous active-low reset, the register reads 0x00 and the serial output is 0.
- R2: A host write with `wr_en` high loads `wr_data`, and the new value appears on `rd_data` after the next clock edge.
- R3: When a host write and a shift event occur in the same cycle, the register takes the written value and no shift happens.
- R4: A shift event moves the register one place left: bit 7 is lost and bit 0 takes the level of `sdi` in that cycle.
- R5: `src_sel` chooses the shift source: 2'b00 software strobe, 2'b01 timer overflow, 2'b10 rising serial clock edge, 2'b11 falling serial clock edge. Events from sources that are not selected have no effect.
- R6: `sclk` passes through a two-flop synchronizer and then an edge detector. The shift caused by a change of `sclk` lands on the third rising `clk` edge after the change, and not before.
- R7: When the software strobe or the timer overflow is selected, `sdo` equals bit 7 of the register in every cycle, including the cycle right after a host write.
- R8: When the rising edge is selected, `sdo` follows bit 7 while the synchronized `sclk` is low and holds its value while it is high. When the falling edge is selected, the phases swap.
- R9: With no write and no selected shift event, the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sel | input | 2 | Shift source select |
| sdi | input | 1 | Serial data input |
| sclk | input | 1 | External serial clock, asynchronous |
| tmr_ovf | input | 1 | Timer overflow pulse, one cycle |
| sw_strobe | input | 1 | Software shift strobe, one cycle |
| wr_en | input | 1 | Host write enable |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Live register value |
| sdo | output | 1 | Serial data output through the latch |

## Verification
The bench applies a write and a strobe in the same cycle. A design that lets the shift win would show the written value moved one place left. It counts `clk` edges after each `sclk` change, so a synchronizer that is one stage short or one stage long shows the shift a cycle early or late. It writes a new MSB while the external clock is in its hold phase and while an internal source is selected. A latch with the wrong phase either leaks the new bit or lags by a cycle. It also pulses sources that are not selected and sends the wrong `sclk` edge, to catch a decoder that mixes up the sources.

// File: rtl/ssu_pkg.sv
// Shared types for the unbuffered serial shift unit.
package ssu_pkg;
    // Shift clock source; the encoding is part of the port contract.
    typedef enum logic [1:0] {
        SRC_STROBE   = 2'b00,
        SRC_TIMER    = 2'b01,
        SRC_EXT_RISE = 2'b10,
        SRC_EXT_FALL = 2'b11
    } ssu_src_e;
endpackage

// File: rtl/ssu_sync_edge.sv
// Synchronizes an asynchronous level into the clk domain and flags its
// edges. Assumes the input stays stable for longer than STAGES+1 clocks.
module ssu_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the asynchronous level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_o;
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = level_o & ~prev_q;
    assign fall_o  = ~level_o & prev_q;

    // R6: a detected edge lasts one cycle only.
    a_r6_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
    a_r6_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/ssu_shift_core.sv
// The live shift register. A host write takes priority over a shift.
// Assumes shift_en is already decoded from the selected source.
module ssu_shift_core #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             sdi,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] data_o
);
    logic [WIDTH-1:0] data_q;

    // Load on write, otherwise shift left with sdi into bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)        data_q <= '0;
        else if (wr_en)    data_q <= wr_data;
        else if (shift_en) data_q <= {data_q[WIDTH-2:0], sdi};
    end

    assign data_o = data_q;

    // R2/R3: a write always lands, even with a shift in the same cycle.
    a_r3_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> data_o == $past(wr_data));
    // R4: a shift moves the old contents left and takes sdi in bit 0.
    a_r4_shift_left: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !wr_en) |=> data_o == {$past(data_o[WIDTH-2:0]), $past(sdi)});
    // R9: no event, no change.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !wr_en) |=> $stable(data_o));
endmodule

// File: rtl/ssu_out_latch.sv
// Output latch between the MSB and the serial output pin. While open_i is
// high the output follows the MSB in the same cycle. While it is low the
// output holds the last value seen while open.
module ssu_out_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic open_i,
    input  logic msb_i,
    output logic sdo_o
);
    logic held_q;

    // Capture the MSB whenever the latch is open.
    always_ff @(posedge clk) begin
        if (!rst_n)      held_q <= 1'b0;
        else if (open_i) held_q <= msb_i;
    end

    assign sdo_o = open_i ? msb_i : held_q;

    // R8: a closed latch keeps the output steady.
    a_r8_closed_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_i && $past(!open_i)) |-> $stable(sdo_o));
endmodule

// File: rtl/ser_shift_unit.sv
// Top of the unbuffered serial shift unit. Selects the shift source, sets
// the phase of the output latch and connects the live register to the host.
// Assumes tmr_ovf and sw_strobe are single-cycle pulses in the clk domain.
module ser_shift_unit
    import ssu_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       src_sel,
    input  logic             sdi,
    input  logic             sclk,
    input  logic             tmr_ovf,
    input  logic             sw_strobe,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data,
    output logic             sdo
);
    localparam int MSB = WIDTH - 1;

    ssu_src_e src;
    logic     sclk_lvl, sclk_rise, sclk_fall;
    logic     shift_en, latch_open;

    assign src = ssu_src_e'(src_sel);

    ssu_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(sclk),
        .level_o(sclk_lvl), .rise_o(sclk_rise), .fall_o(sclk_fall)
    );

    // Pick the shift event and the latch phase for the selected source.
    always_comb begin
        unique case (src)
            SRC_STROBE:   begin shift_en = sw_strobe; latch_open = 1'b1;      end
            SRC_TIMER:    begin shift_en = tmr_ovf;   latch_open = 1'b1;      end
            SRC_EXT_RISE: begin shift_en = sclk_rise; latch_open = ~sclk_lvl; end
            default:      begin shift_en = sclk_fall; latch_open = sclk_lvl;  end
        endcase
    end

    ssu_shift_core #(.WIDTH(WIDTH)) u_core (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .sdi(sdi),
        .wr_en(wr_en), .wr_data(wr_data), .data_o(rd_data)
    );

    ssu_out_latch u_latch (
        .clk(clk), .rst_n(rst_n), .open_i(latch_open),
        .msb_i(rd_data[MSB]), .sdo_o(sdo)
    );

    // R7: with an internal source the pin always shows the MSB.
    a_r7_internal_open: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel[1] == 1'b0) |-> sdo == rd_data[MSB]);
    // R5: an external clock change alone never moves the register while the strobe is selected.
    a_r5_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_STROBE && !sw_strobe && !wr_en) |=> $stable(rd_data));
endmodule

// File: tb/ser_shift_unit_bench.sv
module ser_shift_unit_bench;
    localparam int CLK_PERIOD = 10;

    // Vector: wr, wdata, stb, tmr, sdi, expected register (strobe source)
    typedef struct packed {
        logic       wr;
        logic [7:0] wdata;
        logic       stb;
        logic       tmr;
        logic       sdi;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 8'hA5},  // R2 load
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h4B},  // R4 shift in 1
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h96},  // R4 shift in 0
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h96},  // R5 timer ignored
        '{1'b1, 8'h3C, 1'b1, 1'b0, 1'b1, 8'h3C},  // R3 write wins
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h78},  // R4
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'hF1},  // R4
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'hF1}   // R9 hold
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic       sdi = 1'b0, sclk = 1'b0, tmr_ovf = 1'b0, sw_strobe = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       sdo;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser_shift_unit u_ser_shift_unit (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .sdi(sdi), .sclk(sclk),
        .tmr_ovf(tmr_ovf), .sw_strobe(sw_strobe), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .sdo(sdo)
    );

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: rd_data actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: sdo actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk8("R1", rd_data, 8'h00);
        chk1("R1", sdo, 1'b0);

        // Table walk, strobe source: sdo must track bit 7 (R7)
        foreach (VECS[i]) begin
            wr_en = VECS[i].wr; wr_data = VECS[i].wdata;
            sw_strobe = VECS[i].stb; tmr_ovf = VECS[i].tmr; sdi = VECS[i].sdi;
            @(negedge clk);
            wr_en = 1'b0; sw_strobe = 1'b0; tmr_ovf = 1'b0;
            chk8("R2/R3/R4/R5/R9", rd_data, VECS[i].exp);
            chk1("R7", sdo, VECS[i].exp[7]);
        end

        // Timer source: a timer pulse shifts, a strobe is ignored (R5)
        src_sel = 2'b01;
        host_write(8'h81);
        chk1("R7", sdo, 1'b1);
        sdi = 1'b0; tmr_ovf = 1'b1;
        @(negedge clk); tmr_ovf = 1'b0;
        chk8("R4", rd_data, 8'h02);
        chk1("R7", sdo, 1'b0);
        sw_strobe = 1'b1;
        @(negedge clk); sw_strobe = 1'b0;
        chk8("R5", rd_data, 8'h02);

        // Rising serial clock source
        src_sel = 2'b10;
        host_write(8'h80);
        chk1("R8", sdo, 1'b1);
        sdi = 1'b0; sclk = 1'b1;
        wait_cycles(2);
        chk8("R6", rd_data, 8'h80);
        wait_cycles(1);
        chk8("R6", rd_data, 8'h00);
        chk1("R8", sdo, 1'b1);
        host_write(8'h7F);
        chk8("R2", rd_data, 8'h7F);
        chk1("R8", sdo, 1'b1);
        sclk = 1'b0;
        wait_cycles(3);
        chk8("R5", rd_data, 8'h7F);
        chk1("R8", sdo, 1'b0);

        // Falling serial clock source
        src_sel = 2'b11;
        host_write(8'h01);
        sdi = 1'b1; sclk = 1'b1;
        wait_cycles(3);
        chk8("R5", rd_data, 8'h01);
        chk1("R8", sdo, 1'b0);
        sclk = 1'b0;
        wait_cycles(2);
        chk8("R6", rd_data, 8'h01);
        wait_cycles(1);
        chk8("R4", rd_data, 8'h03);
        chk1("R8", sdo, 1'b0);

        // Reset in mid-run
        src_sel = 2'b00;
        host_write(8'hFF);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk8("R1", rd_data, 8'h00);
        chk1("R1", sdo, 1'b0);

        done = 1'b1;
    end

    initial begin : watchdog
        for (int n = 0; n < 20000 && !done; n++) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule